// File: doc/BRIEF.md
# Variable-Width Vector Element Sequencer

This block steps through the elements of one vector operation whose operands occupy a group of consecutive 32-bit registers. A register can hold one 32-bit element, two 16-bit elements or four 8-bit elements. A start pulse loads the operation's settings:

- the element-width code
- the number of registers in the group
- the requested vector length
- a predicate mask with one bit per element
- a base register number and a vector/scalar flag for each of the two source operands

After the start pulse, the block issues one element access per accepted cycle. Each access gives the element index, the element width, the register number and bit offset for each operand, and an enable taken from the predicate.

Element accesses leave the block on a valid/ready stream. While `out_valid` is high and `out_ready` is low, every field of the access holds its value, and the walk advances only when both signals are high on a clock edge. A one-cycle `done` pulse ends each run. The control pins `start`, `done` and `busy` have no handshake.

Top module: `vec_elem_walker`

## Requirements
- R1: After reset, `out_valid`, `done` and `busy` are all low.
- R2: Width code 3'b001 gives 8-bit elements with four per register, and 3'b010 gives 16-bit elements with two per register. Every other code gives 32-bit elements with one per register. `out_width` reports the element size in bits (8, 16 or 32).
- R3: Element i of a vector operand with base register B and L elements per register lives in register (B + i/L) mod 32, at bit offset (i mod L) × width. The low slice is visited before the high slice, and both come before the next register.
- R4: The number of issued elements is the smaller of the requested length and span × L. A span larger than the `MAX_SPAN` parameter (default 4) is treated as `MAX_SPAN`.
- R5: Indices at or beyond the effective length are never issued, so a run can end partway through a register. For example, 16-bit elements, span 3 and length 5 issue indices 0 to 4 only.
- R6: `out_en` for element i equals bit i of the predicate mask captured at start, combined with the in-length condition.
- R7: For an operand whose vector flag is low, every element reports the operand's base register at offset 0. For an operand whose vector flag is high, each element reports its address per R3.
- R8: A requested length of 0 issues no element. `done` is then high in the cycle that follows the start edge.
- R9: Indices are issued in ascending order starting at 0, advancing by one per accepted handshake. All access fields hold while `out_valid` is high and `out_ready` is low.
- R10: `done` goes high in the cycle after the last handshake and stays high for exactly one cycle.
- R11: A start pulse while `busy` is high has no effect on the run in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Load settings and begin a run (only when idle) |
| width_code | input | 3 | Element-width code |
| span | input | SPAN_W | Registers in the vector group |
| req_len | input | LEN_W | Requested vector length |
| pred_mask | input | MAX_ELEM | Per-element predicate, bit i for element i |
| a_base | input | REG_W | Operand A base register |
| a_vec | input | 1 | Operand A is a vector (1) or scalar (0) |
| b_base | input | REG_W | Operand B base register |
| b_vec | input | 1 | Operand B is a vector (1) or scalar (0) |
| out_ready | input | 1 | Consumer accepts the current access |
| out_valid | output | 1 | An element access is presented |
| out_idx | output | IDX_W | Element index |
| out_en | output | 1 | Element enable (predicate and in-length) |
| out_width | output | 6 | Element width in bits |
| a_reg | output | REG_W | Operand A register number |
| a_off | output | 5 | Operand A bit offset |
| b_reg | output | REG_W | Operand B register number |
| b_off | output | 5 | Operand B bit offset |
| done | output | 1 | One-cycle end-of-run pulse |
| busy | output | 1 | Run or its done cycle in progress |

## Verification
A wrong lane or register counter shows up at the very next accepted element, as a wrong register number or offset. A lost stall shows as a skipped or repeated index on the first cycle in which `out_ready` is low. A wrong effective length, or a done transition taken early or late, shows as an extra or missing element, or as `done` off by one cycle, at the end of that same run. A start that disturbs a run in progress changes the following elements' addresses or enables within a few cycles.

// File: rtl/vew_pkg.sv
package vew_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_FIN  = 2'd2
  } walk_state_t;

  typedef struct packed {
    logic [2:0] lanes;  // elements per 32-bit register
    logic [2:0] shift;  // log2 of element width in bits
  } width_dec_t;

  function automatic width_dec_t decode_width(input logic [2:0] code);
    width_dec_t d;
    case (code)
      3'b001:  begin d.lanes = 3'd4; d.shift = 3'd3; end
      3'b010:  begin d.lanes = 3'd2; d.shift = 3'd4; end
      default: begin d.lanes = 3'd1; d.shift = 3'd5; end
    endcase
    return d;
  endfunction

endpackage

// File: rtl/vew_ctrl.sv
module vew_ctrl
  import vew_pkg::*;
#(
  parameter int MAX_SPAN = 4,
  parameter int SPAN_W   = 3,
  localparam int MAX_ELEM = MAX_SPAN * 4,
  localparam int IDX_W    = $clog2(MAX_ELEM),
  localparam int LEN_W    = $clog2(MAX_ELEM + 1),
  localparam int GRP_W    = (MAX_SPAN > 1) ? $clog2(MAX_SPAN) : 1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                start,
  input  logic [2:0]          width_code,
  input  logic [SPAN_W-1:0]   span,
  input  logic [LEN_W-1:0]    req_len,
  input  logic [MAX_ELEM-1:0] pred_mask,
  input  logic                out_ready,
  output logic                load,
  output logic                run,
  output logic [IDX_W-1:0]    idx,
  output logic                en,
  output logic [GRP_W-1:0]    grp,
  output logic [4:0]          lane_off,
  output logic [5:0]          ew_bits,
  output logic                done,
  output logic                busy
);

  walk_state_t         state;
  logic [LEN_W-1:0]    limit;
  logic [MAX_ELEM-1:0] pred_q;
  logic [1:0]          lane, lanes_m1;
  logic [2:0]          shift_q;

  width_dec_t          dec;
  logic [LEN_W-1:0]    span_c, max_e, lim_n;
  logic                last, in_len;

  always_comb begin
    dec    = decode_width(width_code);
    span_c = (span > SPAN_W'(MAX_SPAN)) ? LEN_W'(MAX_SPAN) : LEN_W'(span);
    max_e  = LEN_W'(span_c * LEN_W'(dec.lanes));
    lim_n  = (req_len > max_e) ? max_e : req_len;
  end

  assign load     = (state == ST_IDLE) && start;
  assign run      = (state == ST_RUN);
  assign done     = (state == ST_FIN);
  assign busy     = (state != ST_IDLE);
  assign in_len   = LEN_W'(idx) < limit;
  assign last     = LEN_W'(idx) == (limit - LEN_W'(1));
  assign en       = pred_q[idx] & in_len;
  assign lane_off = 5'({3'b000, lane} << shift_q);
  assign ew_bits  = 6'(6'd1 << shift_q);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state    <= ST_IDLE;
      limit    <= '0;
      pred_q   <= '0;
      lane     <= '0;
      lanes_m1 <= '0;
      shift_q  <= 3'd5;
      idx      <= '0;
      grp      <= '0;
    end else begin
      case (state)
        ST_IDLE: if (start) begin
          limit    <= lim_n;
          pred_q   <= pred_mask;
          lanes_m1 <= 2'(dec.lanes - 3'd1);
          shift_q  <= dec.shift;
          idx      <= '0;
          lane     <= '0;
          grp      <= '0;
          state    <= (lim_n == '0) ? ST_FIN : ST_RUN;
        end
        ST_RUN: if (out_ready) begin
          if (last) begin
            state <= ST_FIN;
          end else begin
            idx <= idx + IDX_W'(1);
            if (lane == lanes_m1) begin
              lane <= '0;
              grp  <= grp + GRP_W'(1);
            end else begin
              lane <= lane + 2'd1;
            end
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assert_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    run && !out_ready |=> run && $stable(idx) && $stable(lane) && $stable(grp));

  assert_step_R9: assert property (@(posedge clk) disable iff (!rst_n)
    run && out_ready && !last |=> run && (idx == $past(idx) + IDX_W'(1)));

  assert_regstep_R3: assert property (@(posedge clk) disable iff (!rst_n)
    run && out_ready && !last && (lane == lanes_m1) |=> (lane == 2'd0) && (grp == $past(grp) + GRP_W'(1)));

  assert_lane_range_R2: assert property (@(posedge clk) disable iff (!rst_n)
    run |-> lane <= lanes_m1);

  assert_in_len_R5: assert property (@(posedge clk) disable iff (!rst_n)
    run |-> in_len);

  assert_done_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done && !run);

  assert_ignore_start_R11: assert property (@(posedge clk) disable iff (!rst_n)
    busy && start |=> $stable(limit) && $stable(pred_q) && $stable(shift_q));

endmodule

// File: rtl/vew_opsel.sv
module vew_opsel #(
  parameter int REG_W = 5,
  parameter int GRP_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [REG_W-1:0] base_i,
  input  logic             vec_i,
  input  logic             run_i,
  input  logic [GRP_W-1:0] grp_i,
  input  logic [4:0]       off_i,
  output logic [REG_W-1:0] reg_o,
  output logic [4:0]       off_o
);

  logic [REG_W-1:0] base_q;
  logic             vec_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      base_q <= '0;
      vec_q  <= 1'b0;
    end else if (load) begin
      base_q <= base_i;
      vec_q  <= vec_i;
    end
  end

  assign reg_o = vec_q ? REG_W'(base_q + REG_W'(grp_i)) : base_q;
  assign off_o = vec_q ? off_i : 5'd0;

  assert_scalar_fixed_R7: assert property (@(posedge clk) disable iff (!rst_n)
    run_i && $past(run_i) && !vec_q |-> $stable(reg_o) && (off_o == 5'd0));

endmodule

// File: rtl/vec_elem_walker.sv
module vec_elem_walker #(
  parameter int MAX_SPAN = 4,
  parameter int SPAN_W   = 3,
  parameter int REG_W    = 5,
  localparam int MAX_ELEM = MAX_SPAN * 4,
  localparam int IDX_W    = $clog2(MAX_ELEM),
  localparam int LEN_W    = $clog2(MAX_ELEM + 1)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                start,
  input  logic [2:0]          width_code,
  input  logic [SPAN_W-1:0]   span,
  input  logic [LEN_W-1:0]    req_len,
  input  logic [MAX_ELEM-1:0] pred_mask,
  input  logic [REG_W-1:0]    a_base,
  input  logic                a_vec,
  input  logic [REG_W-1:0]    b_base,
  input  logic                b_vec,
  input  logic                out_ready,
  output logic                out_valid,
  output logic [IDX_W-1:0]    out_idx,
  output logic                out_en,
  output logic [5:0]          out_width,
  output logic [REG_W-1:0]    a_reg,
  output logic [4:0]          a_off,
  output logic [REG_W-1:0]    b_reg,
  output logic [4:0]          b_off,
  output logic                done,
  output logic                busy
);

  localparam int GRP_W = (MAX_SPAN > 1) ? $clog2(MAX_SPAN) : 1;
  localparam int NOPS  = 2;

  logic             load, run;
  logic [GRP_W-1:0] grp;
  logic [4:0]       lane_off;

  logic [NOPS-1:0][REG_W-1:0] op_base, op_reg;
  logic [NOPS-1:0]            op_vec;
  logic [NOPS-1:0][4:0]       op_off;

  assign op_base = {b_base, a_base};
  assign op_vec  = {b_vec, a_vec};

  vew_ctrl #(.MAX_SPAN(MAX_SPAN), .SPAN_W(SPAN_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .start(start), .width_code(width_code),
    .span(span), .req_len(req_len), .pred_mask(pred_mask),
    .out_ready(out_ready), .load(load), .run(run), .idx(out_idx),
    .en(out_en), .grp(grp), .lane_off(lane_off), .ew_bits(out_width),
    .done(done), .busy(busy)
  );

  for (genvar g = 0; g < NOPS; g++) begin : g_op
    vew_opsel #(.REG_W(REG_W), .GRP_W(GRP_W)) u_sel (
      .clk(clk), .rst_n(rst_n), .load(load), .base_i(op_base[g]),
      .vec_i(op_vec[g]), .run_i(run), .grp_i(grp), .off_i(lane_off),
      .reg_o(op_reg[g]), .off_o(op_off[g])
    );
  end

  assign out_valid = run;
  assign a_reg = op_reg[0];
  assign a_off = op_off[0];
  assign b_reg = op_reg[1];
  assign b_off = op_off[1];

  assert_no_valid_when_idle_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !out_valid && !done);

  assert_valid_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(a_reg) && $stable(a_off)
      && $stable(b_reg) && $stable(b_off) && $stable(out_en));

endmodule

// File: tb/sim_vec_elem_walker.sv
`timescale 1ns/1ps
module sim_vec_elem_walker;

  localparam int MAX_SPAN = 4;
  localparam int MAX_ELEM = 16;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [2:0]  width_code = '0;
  logic [2:0]  span = '0;
  logic [4:0]  req_len = '0;
  logic [15:0] pred_mask = '0;
  logic [4:0]  a_base = '0, b_base = '0;
  logic        a_vec = 1'b0, b_vec = 1'b0;
  logic        out_ready = 1'b1;
  logic        out_valid, out_en, done, busy;
  logic [3:0]  out_idx;
  logic [5:0]  out_width;
  logic [4:0]  a_reg, a_off, b_reg, b_off;

  vec_elem_walker u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .width_code(width_code),
    .span(span), .req_len(req_len), .pred_mask(pred_mask),
    .a_base(a_base), .a_vec(a_vec), .b_base(b_base), .b_vec(b_vec),
    .out_ready(out_ready), .out_valid(out_valid), .out_idx(out_idx),
    .out_en(out_en), .out_width(out_width), .a_reg(a_reg), .a_off(a_off),
    .b_reg(b_reg), .b_off(b_off), .done(done), .busy(busy)
  );

  always #2.5 clk = ~clk;

  typedef struct {
    int idx; int en; int w; int ar; int ao; int br; int bo;
  } item_t;

  item_t q[$];
  int checks = 0, fails = 0;
  int cyc = 0, last_hs = -1;
  bit bp_mode = 0;
  logic [7:0] lfsr = 8'hA7;

  always @(posedge clk) cyc <= cyc + 1;

  always @(posedge clk) begin
    #1;
    out_ready = bp_mode ? lfsr[0] : 1'b1;
    lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
  end

  task automatic check(input bit ok, input string tag, input string what);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s", tag, what);
    end
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (rst_n && out_valid && out_ready) begin
      last_hs = cyc;
      if (q.size() == 0) begin
        check(0, "R5", $sformatf("unexpected element idx %0d (actual) vs none (expected)", out_idx));
      end else begin
        item_t e;
        e = q.pop_front();
        check(out_idx == e.idx, "R9",
              $sformatf("idx %0d expected %0d", out_idx, e.idx));
        check(out_width == e.w, "R2",
              $sformatf("width %0d expected %0d", out_width, e.w));
        check(out_en == e.en, "R6",
              $sformatf("en %0d expected %0d at idx %0d", out_en, e.en, e.idx));
        check(a_reg == e.ar && a_off == e.ao, "R3",
              $sformatf("A reg/off %0d/%0d expected %0d/%0d at idx %0d", a_reg, a_off, e.ar, e.ao, e.idx));
        check(b_reg == e.br && b_off == e.bo, "R7",
              $sformatf("B reg/off %0d/%0d expected %0d/%0d at idx %0d", b_reg, b_off, e.br, e.bo, e.idx));
      end
    end
  end

  task automatic run_case(input int code, input int sp, input int len, input int pred,
                          input int ab, input int av, input int bb, input int bv,
                          input bit bp, input bit inject);
    int lanes, w, spc, lim, st_cyc, done_cyc;
    bit seen;
    lanes = (code == 1) ? 4 : (code == 2) ? 2 : 1;
    w = 32 / lanes;
    spc = (sp > MAX_SPAN) ? MAX_SPAN : sp;
    lim = (len < spc * lanes) ? len : spc * lanes;
    for (int i = 0; i < lim; i++) begin
      item_t e;
      e.idx = i; e.w = w; e.en = (pred >> i) & 1;
      e.ar = av ? (ab + i / lanes) % 32 : ab;
      e.ao = av ? (i % lanes) * w : 0;
      e.br = bv ? (bb + i / lanes) % 32 : bb;
      e.bo = bv ? (i % lanes) * w : 0;
      q.push_back(e);
    end
    bp_mode = bp;
    @(negedge clk);
    width_code = code[2:0]; span = sp[2:0]; req_len = len[4:0];
    pred_mask = pred[15:0]; a_base = ab[4:0]; a_vec = av[0];
    b_base = bb[4:0]; b_vec = bv[0]; start = 1'b1;
    st_cyc = cyc;
    seen = 0; done_cyc = -1;
    for (int k = 0; k < 400 && !seen; k++) begin
      @(negedge clk);
      start = 1'b0;
      if (inject && k == 2) begin
        // R11: foreign settings while busy
        width_code = 3'b010; span = 3'd1; req_len = 5'd1; pred_mask = '0;
        a_base = 5'd9; a_vec = 1'b0; b_base = 5'd11; b_vec = 1'b1; start = 1'b1;
      end
      if (done) begin seen = 1; done_cyc = cyc; end
    end
    start = 1'b0;
    check(seen, "R10", $sformatf("done seen %0d expected 1", seen));
    check(q.size() == 0, "R4", $sformatf("pending elements %0d expected 0", q.size()));
    if (lim == 0)
      check(done_cyc == st_cyc + 1, "R8", $sformatf("done cycle %0d expected %0d", done_cyc, st_cyc + 1));
    else
      check(done_cyc == last_hs + 1, "R10", $sformatf("done cycle %0d expected %0d", done_cyc, last_hs + 1));
    @(negedge clk);
    check(!done && !busy, "R10", $sformatf("done/busy %0d/%0d expected 0/0", done, busy));
    q.delete();
  endtask

  initial begin
    #(200000 * 5);
    checks++; fails++;
    $display("FAIL watchdog expired: actual hung, expected finish");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(!out_valid && !done && !busy, "R1",
          $sformatf("valid/done/busy %0d/%0d/%0d expected 0/0/0", out_valid, done, busy));
    // R3 R5 R7: 16-bit, span 3, length 5 stops inside third register
    run_case(2, 3, 5, 16'hFFFF, 2, 1, 7, 0, 0, 0);
    // R2 R4 R6 R9: 8-bit, length clamped to 8, predicate pattern, back-pressure
    run_case(1, 2, 16, 16'h00A5, 4, 1, 20, 1, 1, 0);
    // R2: code 000 behaves as 32-bit
    run_case(0, 4, 3, 16'h0005, 10, 1, 1, 0, 1, 0);
    // R4: code 111 as 32-bit, span 7 clamped to 4
    run_case(7, 7, 16, 16'h000E, 12, 0, 13, 1, 0, 0);
    // R8: zero length
    run_case(2, 3, 0, 16'hFFFF, 2, 1, 3, 1, 0, 0);
    // R3: register wrap past 31
    run_case(1, 3, 12, 16'h0F0F, 31, 1, 30, 1, 1, 0);
    // R11: start while busy is ignored
    run_case(1, 4, 16, 16'h3C3C, 5, 1, 6, 0, 0, 1);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule